// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead-Time

This block turns one digital direction command into the four gate requests of an H-bridge built from N-channel switches: an upper and a lower switch for each of the two legs, A and B. With the command high, current is steered one way through the load: A-upper and B-lower on. With the command low it is steered the other way: A-lower and B-upper on. Every gate request drops on the clock edge after its request goes away. It rises only after a programmable number of cycles, so the outgoing switch of a leg is always off before the incoming one turns on. One delay count serves both upper switches and another serves both lower switches.

Two overrides sit above the command. A disable input turns all four gates off and takes precedence over everything else. An upper-enable input, when low, keeps both upper switches off while the lower switches still follow the command, so that load current freewheels through the bottom of the bridge. The command, disable and upper-enable inputs may be asynchronous. Each passes through a two-flop synchronizer. The synchronized command is returned on an echo output for use in an external feedback loop.

Top module: `fbg_top`

## Requirements
- R1: With the synchronized command high and no override active, gate_ah and gate_bl turn on (each after its turn-on delay) and gate_al and gate_bh stay low.
- R2: With the synchronized command low and no override active, gate_al and gate_bh turn on (each after its turn-on delay) and gate_ah and gate_bl stay low.
- R3: A synchronized disable level of 1 drives all four gates low on the next clock edge and holds them low whatever the command, enable or delay inputs do.
- R4: A synchronized upper-enable level of 0 drives gate_ah and gate_bh low on the next clock edge, while gate_al and gate_bl keep following the command.
- R5: A gate turns off on the first clock edge after its request is withdrawn, with no added delay. Counting from an input change driven between edges, that is the third edge.
- R6: A gate whose request first appears (after synchronization) in cycle t is high from cycle t+1+D. D is hi_dly for both upper gates and lo_dly for both lower gates, read as unsigned 8-bit cycle counts. Counting from an input change, the gate is seen high after 3+D edges.
- R7: A delay count of 0 is legal and turns the gate on at the first edge after its request appears. Within a leg the outgoing gate then falls and the incoming gate rises on the same edge.
- R8: While rst_n is low and after it is released, all gates are low and cmd_echo is 0. The synchronized disable and upper-enable both read 1 until the real input levels have passed the synchronizer, so the gates stay low until disable is driven low.
- R9: If a request is withdrawn before its delay count has expired, the count is discarded and the gate never pulses. A later request starts a fresh full delay.
- R10: In every cycle the upper and lower gates of the same leg are never both high.
- R11: cmd_in passes through two flip-flops before use, and cmd_echo equals cmd_in as sampled two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_in | input | 1 | Direction command, asynchronous |
| hi_en_in | input | 1 | Upper-switch enable, asynchronous, 0 keeps both upper gates off |
| dis_in | input | 1 | Disable, asynchronous, 1 forces all gates off |
| hi_dly | input | 8 | Turn-on delay in cycles for both upper gates |
| lo_dly | input | 8 | Turn-on delay in cycles for both lower gates |
| gate_ah | output | 1 | Leg A upper gate request |
| gate_al | output | 1 | Leg A lower gate request |
| gate_bh | output | 1 | Leg B upper gate request |
| gate_bl | output | 1 | Leg B lower gate request |
| cmd_echo | output | 1 | Synchronized command |

## Verification
A turn-on counter stuck or off by one shows up as a gate that rises a cycle early or late. That appears within at most 3+D cycles of the command change that started it. A counter that survives a withdrawn request shows up as a short pulse, or as an early rise on the next request of the same gate. A wrong synchronizer reset value or an override applied at the wrong stage shows up in the first few cycles after reset, or in the edge after the override changes. The bench therefore compares all five outputs against an independent model on every cycle, so any such error is reported in the cycle it first reaches a port.

// File: rtl/fbg_pkg.sv
// Shared definitions for the full-bridge gate sequencer.
// Assumes the four switch positions are indexed as listed in sw_e.
package fbg_pkg;

    typedef enum logic [1:0] {
        SW_AH = 2'd0,
        SW_AL = 2'd1,
        SW_BH = 2'd2,
        SW_BL = 2'd3
    } sw_e;

    localparam int NUM_SW = 4;

    // True for the upper switch of either leg.
    function automatic bit is_upper(input int idx);
        return (idx == int'(SW_AH)) || (idx == int'(SW_BH));
    endfunction

endpackage

// File: rtl/fbg_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2. Resets every stage to RST_VAL so that the
// output reads a chosen safe level until real samples arrive.
module fbg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the input level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fbg_steer.sv
// Combinational request steering for the four bridge switches.
// Disable has top precedence, then upper-enable, then the command.
// Assumes all inputs are already synchronized.
module fbg_steer
    import fbg_pkg::*;
(
    input  logic              cmd,
    input  logic              hi_en,
    input  logic              dis,
    output logic [NUM_SW-1:0] req
);

    // Map command and overrides to per-switch on requests.
    always_comb begin
        req        = '0;
        req[SW_AH] = !dis && hi_en && cmd;
        req[SW_BL] = !dis && cmd;
        req[SW_AL] = !dis && !cmd;
        req[SW_BH] = !dis && hi_en && !cmd;
    end

endmodule

// File: rtl/fbg_turnon.sv
// Turn-on delay channel for one gate: drops the gate on the edge after
// its request is withdrawn, raises it DLY cycles after the request
// appears. A withdrawn request clears the count, so no pulse escapes.
// Assumes dly may change at any time; it is compared live.
module fbg_turnon #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [DLY_W-1:0] dly,
    output logic             gate
);

    logic [DLY_W-1:0] cnt;

    // Count request cycles and switch the gate on once the delay is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= 1'b0;
            cnt  <= '0;
        end else if (!req) begin
            gate <= 1'b0;
            cnt  <= '0;
        end else if (!gate) begin
            if (cnt >= dly) gate <= 1'b1;
            else            cnt  <= cnt + 1'b1;
        end
    end

    // R5: a withdrawn request turns the gate off on the next edge.
    p_fast_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !gate);

    // R9: a gate never rises without a request present at the edge.
    p_no_orphan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> $past(req));

    // R6: once on, the gate holds while its request stays.
    p_hold_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && gate) |=> gate);

endmodule

// File: rtl/fbg_top.sv
// Full-bridge gate sequencer. Synchronizes the command and both
// overrides, steers them to four switch requests and applies the
// shared upper and lower turn-on delays.
// Assumes hi_dly/lo_dly are quasi-static and synchronous to clk.
module fbg_top
    import fbg_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_in,
    input  logic             hi_en_in,
    input  logic             dis_in,
    input  logic [DLY_W-1:0] hi_dly,
    input  logic [DLY_W-1:0] lo_dly,
    output logic             gate_ah,
    output logic             gate_al,
    output logic             gate_bh,
    output logic             gate_bl,
    output logic             cmd_echo
);

    logic              cmd_s;
    logic              hen_s;
    logic              dis_s;
    logic [NUM_SW-1:0] req;
    logic [NUM_SW-1:0] gate;

    // Command resets low; overrides reset to their safe levels.
    fbg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cmd (
        .clk(clk), .rst_n(rst_n), .d(cmd_in), .q(cmd_s));
    fbg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hen (
        .clk(clk), .rst_n(rst_n), .d(hi_en_in), .q(hen_s));
    fbg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dis (
        .clk(clk), .rst_n(rst_n), .d(dis_in), .q(dis_s));

    fbg_steer u_steer (
        .cmd(cmd_s), .hi_en(hen_s), .dis(dis_s), .req(req));

    // One delay channel per switch; upper ones share hi_dly.
    for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
        localparam bit UPPER = is_upper(i);
        logic [DLY_W-1:0] dly_sel;
        if (UPPER) begin : g_hi
            assign dly_sel = hi_dly;
        end else begin : g_lo
            assign dly_sel = lo_dly;
        end
        fbg_turnon #(.DLY_W(DLY_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .req(req[i]),
            .dly(dly_sel), .gate(gate[i]));
    end

    assign gate_ah  = gate[SW_AH];
    assign gate_al  = gate[SW_AL];
    assign gate_bh  = gate[SW_BH];
    assign gate_bl  = gate[SW_BL];
    assign cmd_echo = cmd_s;

    // R10: never both switches of leg A on.
    p_leg_a_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_ah && gate_al));

    // R10: never both switches of leg B on.
    p_leg_b_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_bh && gate_bl));

    // R3: synchronized disable clears every gate on the next edge.
    p_dis_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dis_s |=> (gate == '0));

    // R4: upper-enable low clears both upper gates on the next edge.
    p_hen_upper_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hen_s |=> (!gate_ah && !gate_bh));

    // R1/R2: a gate on implies the command had its direction.
    p_dir_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ah) |-> $past(cmd_s));

endmodule

// File: tb/sim_fbg_top.sv
`timescale 1ns/1ps
module sim_fbg_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_in, hi_en_in, dis_in;
    logic [7:0] hi_dly, lo_dly;
    logic       gate_ah, gate_al, gate_bh, gate_bl, cmd_echo;

    int    errors = 0;
    int    checks = 0;
    string phase  = "R8";
    bit    done   = 1'b0;

    // Reference model state: sync pipelines, gate states and request ages.
    int m_c1, m_c2, m_h1, m_h2, m_d1, m_d2;
    int m_out [4];
    int m_age [4];

    always #10 clk = ~clk;

    fbg_top u0 (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .hi_en_in(hi_en_in),
        .dis_in(dis_in), .hi_dly(hi_dly), .lo_dly(lo_dly),
        .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh),
        .gate_bl(gate_bl), .cmd_echo(cmd_echo));

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Advance the model by one edge using the inputs present at the edge.
    task automatic model_edge();
        int req [4];
        int d;
        if (!rst_n) begin
            m_c1 = 0; m_c2 = 0; m_h1 = 1; m_h2 = 1; m_d1 = 1; m_d2 = 1;
            for (int i = 0; i < 4; i++) begin m_out[i] = 0; m_age[i] = 0; end
            return;
        end
        req[0] = (m_d2 == 0 && m_h2 == 1 && m_c2 == 1);  // A upper
        req[1] = (m_d2 == 0 && m_c2 == 0);               // A lower
        req[2] = (m_d2 == 0 && m_h2 == 1 && m_c2 == 0);  // B upper
        req[3] = (m_d2 == 0 && m_c2 == 1);               // B lower
        for (int i = 0; i < 4; i++) begin
            d = (i == 0 || i == 2) ? int'(hi_dly) : int'(lo_dly);
            if (req[i] != 0) begin
                if (m_out[i] == 0 && m_age[i] >= d) m_out[i] = 1;
                m_age[i] = m_age[i] + 1;
            end else begin
                m_out[i] = 0;
                m_age[i] = 0;
            end
        end
        m_c2 = m_c1; m_c1 = int'(cmd_in);
        m_h2 = m_h1; m_h1 = int'(hi_en_in);
        m_d2 = m_d1; m_d1 = int'(dis_in);
    endtask

    // One clock: model update at the edge, compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (done) return;
        chk(phase, "gate_ah", int'(gate_ah), m_out[0]);
        chk(phase, "gate_al", int'(gate_al), m_out[1]);
        chk(phase, "gate_bh", int'(gate_bh), m_out[2]);
        chk(phase, "gate_bl", int'(gate_bl), m_out[3]);
        chk("R11", "cmd_echo", int'(cmd_echo), m_c2);
        chk("R10", "leg A overlap", int'(gate_ah && gate_al), 0);
        chk("R10", "leg B overlap", int'(gate_bh && gate_bl), 0);
    endtask

    function automatic logic gate_sel(input int idx);
        case (idx)
            0: return gate_ah;
            1: return gate_al;
            2: return gate_bh;
            default: return gate_bl;
        endcase
    endfunction

    // Ticks until the selected gate is seen high (limit 400).
    task automatic rise_time(input int idx, output int n);
        n = 0;
        while (gate_sel(idx) == 1'b0 && n < 400) begin tick(); n++; end
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic [15:0] lfsr;
        bit seen;
        rst_n = 1'b0; cmd_in = 1'b1; hi_en_in = 1'b1; dis_in = 1'b1;
        hi_dly = 8'd3; lo_dly = 8'd2;
        @(negedge clk);
        phase = "R8";
        run(4);
        chk("R8", "gates in reset", int'({gate_ah, gate_al, gate_bh, gate_bl}), 0);
        chk("R8", "echo in reset", int'(cmd_echo), 0);
        rst_n = 1'b1;
        run(6);
        chk("R8", "gates with disable held", int'({gate_ah, gate_al, gate_bh, gate_bl}), 0);

        // R1 and R6: enable with command high, measure delays.
        phase = "R1";
        dis_in = 1'b0;
        rise_time(0, n);
        chk("R6", "gate_ah rise latency (3+hi_dly=6)", n, 6);
        chk("R1", "gate_bl on", int'(gate_bl), 1);
        chk("R1", "gate_al off", int'(gate_al), 0);
        run(4);

        // R2, R5: reverse; upper A drops on third edge.
        phase = "R2";
        cmd_in = 1'b0;
        run(2);
        chk("R5", "gate_ah still on after 2 edges", int'(gate_ah), 1);
        tick();
        chk("R5", "gate_ah off after 3 edges", int'(gate_ah), 0);
        run(8);
        chk("R2", "gate_bh on", int'(gate_bh), 1);
        chk("R2", "gate_al on", int'(gate_al), 1);

        // R7: zero delays, same-edge handover.
        phase = "R7";
        hi_dly = 8'd0; lo_dly = 8'd0;
        cmd_in = 1'b1;
        rise_time(3, n);
        chk("R7", "gate_bl rise latency (3)", n, 3);
        chk("R7", "gate_bh off at handover", int'(gate_bh), 0);
        chk("R7", "gate_ah on at handover", int'(gate_ah), 1);
        run(3);

        // R4: upper enable low, lower gates still follow command.
        phase = "R4";
        hi_dly = 8'd2; lo_dly = 8'd1;
        hi_en_in = 1'b0;
        run(3);
        chk("R4", "gate_ah forced off", int'(gate_ah), 0);
        cmd_in = 1'b0;
        run(8);
        chk("R4", "gate_bh held off", int'(gate_bh), 0);
        chk("R4", "gate_al follows command", int'(gate_al), 1);
        hi_en_in = 1'b1;
        run(8);

        // R9: withdrawn request before delay expires: no pulse.
        phase = "R9";
        lo_dly = 8'd20;
        cmd_in = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 8; k++) begin tick(); if (gate_bl) seen = 1'b1; end
        cmd_in = 1'b0;
        for (int k = 0; k < 30; k++) begin tick(); if (gate_bl) seen = 1'b1; end
        chk("R9", "gate_bl pulsed", int'(seen), 0);
        lo_dly = 8'd4;
        cmd_in = 1'b1;
        rise_time(3, n);
        chk("R9", "fresh delay after cancel (3+4)", n, 7);

        // R3: disable in mid-run overrides everything.
        phase = "R3";
        dis_in = 1'b1;
        run(3);
        chk("R3", "all gates off", int'({gate_ah, gate_al, gate_bh, gate_bl}), 0);
        cmd_in = 1'b0; hi_en_in = 1'b0; lo_dly = 8'd0; hi_dly = 8'd0;
        run(5);
        chk("R3", "still off under input churn", int'({gate_ah, gate_al, gate_bh, gate_bl}), 0);
        dis_in = 1'b0; hi_en_in = 1'b1;

        // Mixed patterns: all outputs compared each cycle against the model.
        phase = "R6";
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) cmd_in = ~cmd_in;
            if (lfsr[7:3] == 5'd1) hi_en_in = ~hi_en_in;
            if (lfsr[9:4] == 6'd2) dis_in = ~dis_in;
            if (lfsr[11:8] == 4'd3) hi_dly = {5'd0, lfsr[14:12]};
            if (lfsr[11:8] == 4'd5) lo_dly = {5'd0, lfsr[15:13]};
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule